// File: doc/BRIEF.md
# Vertical Line Decimation Filter

This block shrinks the height of a picture-in-picture window. It takes one component of a video signal (luma or one colour-difference channel) as a stream of samples, with a strobe that marks the first sample of each line and a strobe that marks the first line of each field. It folds each run of N consecutive lines into one output line. Each input line is scaled by a fixed weight in sixteenths, and the weights of a group add up to exactly one. Groups do not overlap, so the block gives one output line for every N input lines.

A 2-bit mode input selects N and the weight set. The block samples the mode only on the first line of a field, so a change made mid-field waits for the next field. The block keeps one running sum per column in an on-chip array that is one line long. On the last line of a group, the block rounds and saturates the finished sum and emits it with a valid strobe, one result per input sample of that line.

Top module: `vline_decim`

## Requirements
- R1: The mode input sets the group size: 00 combines 3 lines, 01 combines 4, 10 combines 5 and 11 combines 6. Exactly one output line follows each complete group.
- R2: In mode 00 the lines of a group are weighted 4, 8, 4 (in sixteenths), in arrival order.
- R3: In mode 01 the weights are 2, 6, 6, 2 sixteenths.
- R4: In mode 10 the weights are 1, 4, 6, 4, 1 sixteenths.
- R5: In mode 11 the weights are 1, 3, 4, 4, 3, 1 sixteenths.
- R6: Each output sample equals floor((sum of weight times sample + 8) / 16), limited to the largest 8-bit value 255.
- R7: outValid is high for one cycle per sample of the last line of a group. It appears exactly 2 clock cycles after that sample was presented. No other cycle has outValid high.
- R8: The first line of a field (a sample with sampleValid, lineStart and fieldStart all high) always starts a new group. Lines of an unfinished group left at that point give no output.
- R9: The mode input is captured only on the first line of a field. A change at any other time has no effect until the next field starts.
- R10: While reset (rstN low) is asserted, outValid and outData are 0. After reset, no output is produced until the first field start, and the active mode defaults to 00.
- R11: In each line, samples at column LINE_LEN and beyond are ignored. They produce no output and do not disturb the stored sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | Reduction mode: 00 = 1/3, 01 = 1/4, 10 = 1/5, 11 = 1/6 |
| sampleValid | input | 1 | sampleIn carries a sample this cycle |
| lineStart | input | 1 | Marks the first sample of a line (qualified by sampleValid) |
| fieldStart | input | 1 | Together with lineStart, marks the first line of a field |
| sampleIn | input | DATA_W | Input sample |
| outValid | output | 1 | outData holds a decimated sample |
| outData | output | DATA_W | Decimated, rounded and saturated sample |

## Verification
Each sample presented on the last line of a group gives its result exactly two clock edges later: one edge loads the stage register and the next loads the output register. The driver task computes each expected result from the weight tables and the rounding rule, and stamps it with the cycle number two after the cycle in which it drives the sample. The monitor samples at the falling edge and requires each output to arrive in its stamped cycle. It reports a FAIL for an output that arrives early or late, for an output nobody expected, and for an expected output that never comes. Lines given before the first field, partial groups, mid-field mode changes and over-long lines push no expected items, so any output caused by them shows up as unexpected.

// File: rtl/vline_decim_pkg.sv
package vline_decim_pkg;

  // Weights are integers in sixteenths; this many fraction bits.
  localparam int WEIGHT_FRAC = 4;
  localparam int WEIGHT_W    = 5;

  // Strobes handed from control to datapath for each accepted sample.
  typedef struct packed {
    logic                sampleEn;
    logic                groupFirst;
    logic                groupLast;
    logic [WEIGHT_W-1:0] weight;
  } tapStrobe_t;

  // Lines per group for a mode: 3..6.
  function automatic logic [2:0] tapCount(input logic [1:0] mode);
    return 3'({1'b0, mode}) + 3'd3;
  endfunction

  // Symmetric weight sets, each summing to 16.
  function automatic logic [WEIGHT_W-1:0] tapWeight(input logic [1:0] mode,
                                                    input logic [2:0] idx);
    logic [WEIGHT_W-1:0] w;
    w = '0;
    unique case (mode)
      2'b00: case (idx)
               3'd0, 3'd2: w = 5'd4;
               3'd1:       w = 5'd8;
               default:    w = '0;
             endcase
      2'b01: case (idx)
               3'd0, 3'd3: w = 5'd2;
               3'd1, 3'd2: w = 5'd6;
               default:    w = '0;
             endcase
      2'b10: case (idx)
               3'd0, 3'd4: w = 5'd1;
               3'd1, 3'd3: w = 5'd4;
               3'd2:       w = 5'd6;
               default:    w = '0;
             endcase
      default: case (idx)
               3'd0, 3'd5: w = 5'd1;
               3'd1, 3'd4: w = 5'd3;
               3'd2, 3'd3: w = 5'd4;
               default:    w = '0;
             endcase
    endcase
    return w;
  endfunction

endpackage

// File: rtl/vline_decim_ctrl.sv
module vline_decim_ctrl
  import vline_decim_pkg::*;
#(
  parameter int LINE_LEN = 720,
  parameter int IDX_W    = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             sampleValid,
  input  logic             lineStart,
  input  logic             fieldStart,
  output tapStrobe_t       strobe,
  output logic [IDX_W-1:0] colAddr
);

  localparam int COL_W = $clog2(LINE_LEN + 1);

  logic             armed;
  logic [1:0]       activeMode;
  logic [2:0]       lineIdx;
  logic [COL_W-1:0] colCnt;

  logic             lineOpen;
  logic             fieldOpen;
  logic             effArmed;
  logic             inRange;
  logic [1:0]       effMode;
  logic [2:0]       effIdx;
  logic [2:0]       lastIdxRun;
  logic [2:0]       lastIdxEff;
  logic [COL_W-1:0] effCol;

  always_comb begin
    lineOpen   = sampleValid & lineStart;
    fieldOpen  = lineOpen & fieldStart;
    lastIdxRun = tapCount(activeMode) - 3'd1;
    effMode    = fieldOpen ? modeSel : activeMode;
    lastIdxEff = tapCount(effMode) - 3'd1;
    if (fieldOpen)     effIdx = 3'd0;
    else if (lineOpen) effIdx = (lineIdx == lastIdxRun) ? 3'd0 : lineIdx + 3'd1;
    else               effIdx = lineIdx;
    effCol   = lineOpen ? '0 : colCnt;
    effArmed = armed | fieldOpen;
    inRange  = effCol < COL_W'(LINE_LEN);

    strobe.sampleEn   = sampleValid & effArmed & inRange;
    strobe.groupFirst = (effIdx == 3'd0);
    strobe.groupLast  = (effIdx == lastIdxEff);
    strobe.weight     = tapWeight(effMode, effIdx);
    colAddr           = effCol[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed      <= 1'b0;
      activeMode <= 2'b00;
      lineIdx    <= 3'd0;
      colCnt     <= '0;
    end else if (sampleValid) begin
      armed      <= effArmed;
      activeMode <= effMode;
      lineIdx    <= effIdx;
      colCnt     <= inRange ? effCol + COL_W'(1) : effCol;
    end
  end

endmodule

// File: rtl/vline_decim_datapath.sv
module vline_decim_datapath
  import vline_decim_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LINE_LEN = 720,
  parameter int IDX_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  tapStrobe_t        strobe,
  input  logic [IDX_W-1:0]  colAddr,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  localparam int ACC_W  = DATA_W + WEIGHT_FRAC + 1;
  localparam int SHR_W  = ACC_W + 1 - WEIGHT_FRAC;
  localparam int BIAS   = 1 << (WEIGHT_FRAC - 1);

  tapStrobe_t        stStrobe;
  logic [IDX_W-1:0]  stAddr;
  logic [DATA_W-1:0] stData;

  logic [ACC_W-1:0]  accMem [LINE_LEN];

  logic [ACC_W-1:0]  product;
  logic [ACC_W-1:0]  base;
  logic [ACC_W-1:0]  sum;
  logic [ACC_W:0]    rounded;
  logic [SHR_W-1:0]  shifted;
  logic [DATA_W-1:0] clipped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stStrobe <= '0;
      stAddr   <= '0;
      stData   <= '0;
    end else begin
      stStrobe <= strobe;
      stAddr   <= colAddr;
      stData   <= sampleIn;
    end
  end

  always_comb begin
    product = ACC_W'(stData) * ACC_W'(stStrobe.weight);
    base    = stStrobe.groupFirst ? '0 : accMem[stAddr];
    sum     = base + product;
    rounded = {1'b0, sum} + (ACC_W + 1)'(BIAS);
    shifted = rounded[ACC_W:WEIGHT_FRAC];
    clipped = (|shifted[SHR_W-1:DATA_W]) ? '1 : shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (stStrobe.sampleEn) accMem[stAddr] <= sum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= stStrobe.sampleEn & stStrobe.groupLast;
      if (stStrobe.sampleEn & stStrobe.groupLast) outData <= clipped;
    end
  end

endmodule

// File: rtl/vline_decim.sv
module vline_decim
  import vline_decim_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LINE_LEN = 720
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              sampleValid,
  input  logic              lineStart,
  input  logic              fieldStart,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  localparam int IDX_W = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;

  tapStrobe_t       strobe;
  logic [IDX_W-1:0] colAddr;

  vline_decim_ctrl #(
    .LINE_LEN (LINE_LEN),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeSel     (modeSel),
    .sampleValid (sampleValid),
    .lineStart   (lineStart),
    .fieldStart  (fieldStart),
    .strobe      (strobe),
    .colAddr     (colAddr)
  );

  vline_decim_datapath #(
    .DATA_W   (DATA_W),
    .LINE_LEN (LINE_LEN),
    .IDX_W    (IDX_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .colAddr  (colAddr),
    .sampleIn (sampleIn),
    .outValid (outValid),
    .outData  (outData)
  );

endmodule

// File: rtl/vline_decim_checker.sv
module vline_decim_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sampleValid,
  input logic       lineStart,
  input logic       fieldStart,
  input logic       outValid,
  input logic       stbEn,
  input logic       stbFirst,
  input logic       stbLast,
  input logic [4:0] stbWeight
);

  logic seenField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenField <= 1'b0;
    else if (sampleValid && lineStart && fieldStart) seenField <= 1'b1;
  end

  // R7: every output traces back to a sample two cycles earlier
  a_r7_valid_follows_sample: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sampleValid, 2));

  // R10: nothing comes out before the first field start
  a_r10_no_output_before_field: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> seenField);

  // R8: a field start always opens a fresh group
  a_r8_field_opens_group: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && lineStart && fieldStart && stbEn) |-> stbFirst);

  // R1: the outer lines of every group carry a small edge weight
  a_r1_first_edge_weight: assert property (@(posedge clk) disable iff (!rstN)
    (stbEn && stbFirst) |-> (stbWeight == 5'd1 || stbWeight == 5'd2 || stbWeight == 5'd4));

  // R1: a group never closes on the line that opened it
  a_r1_first_not_last: assert property (@(posedge clk) disable iff (!rstN)
    (stbEn && stbFirst) |-> !stbLast);

endmodule

bind vline_decim vline_decim_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .lineStart   (lineStart),
  .fieldStart  (fieldStart),
  .outValid    (outValid),
  .stbEn       (strobe.sampleEn),
  .stbFirst    (strobe.groupFirst),
  .stbLast     (strobe.groupLast),
  .stbWeight   (strobe.weight)
);

// File: tb/vline_decim_test.sv
module vline_decim_test;

  localparam int DATA_W   = 8;
  localparam int LINE_LEN = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        modeSel = 2'b00;
  logic              sampleValid = 1'b0;
  logic              lineStart = 1'b0;
  logic              fieldStart = 1'b0;
  logic [DATA_W-1:0] sampleIn = '0;
  logic              outValid;
  logic [DATA_W-1:0] outData;

  vline_decim #(.DATA_W(DATA_W), .LINE_LEN(LINE_LEN)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .sampleValid(sampleValid),
    .lineStart(lineStart), .fieldStart(fieldStart), .sampleIn(sampleIn),
    .outValid(outValid), .outData(outData)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    data;
    longint due;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int      checks = 0;
  int      errors = 0;
  int      outSeen = 0;
  int      pushed = 0;
  longint  cycleCount = 0;
  bit      done = 1'b0;

  // Independent model state
  bit      mArmed = 1'b0;
  int      mMode = 0;
  int      mIdx = 0;
  int      mAcc [LINE_LEN];

  always @(posedge clk) cycleCount <= cycleCount + 1;

  function automatic int groupSize(int mode);
    return mode + 3;
  endfunction

  function automatic int refWeight(int mode, int idx);
    case (mode)
      0: case (idx) 0: return 4; 1: return 8; 2: return 4; default: return 0; endcase
      1: case (idx) 0: return 2; 1: return 6; 2: return 6; 3: return 2; default: return 0; endcase
      2: case (idx) 0: return 1; 1: return 4; 2: return 6; 3: return 4; 4: return 1; default: return 0; endcase
      default: case (idx) 0: return 1; 1: return 3; 2: return 4; 3: return 4; 4: return 3; 5: return 1; default: return 0; endcase
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: drives one line and pushes the expected results
  task automatic driveLine(bit fs, int len, int base, int step, int gap, string tag);
    for (int c = 0; c < len; c++) begin
      int x;
      @(negedge clk);
      x = (base + c * step) & 255;
      sampleValid = 1'b1;
      lineStart   = (c == 0);
      fieldStart  = fs && (c == 0);
      sampleIn    = DATA_W'(x);
      if (c == 0) begin
        if (fs) begin
          mArmed = 1'b1;
          mMode  = int'(modeSel);
          mIdx   = 0;
        end else begin
          mIdx = (mIdx == groupSize(mMode) - 1) ? 0 : mIdx + 1;
        end
      end
      if (mArmed && c < LINE_LEN) begin
        int w;
        w = refWeight(mMode, mIdx);
        mAcc[c] = (mIdx == 0) ? w * x : mAcc[c] + w * x;
        if (mIdx == groupSize(mMode) - 1) begin
          expItem_t it;
          int r;
          r = (mAcc[c] + 8) / 16;
          it.data = (r > 255) ? 255 : r;
          it.due  = cycleCount + 2;
          it.tag  = tag;
          expQ.push_back(it);
          pushed++;
        end
      end
    end
    @(negedge clk);
    sampleValid = 1'b0;
    lineStart   = 1'b0;
    fieldStart  = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: compares outputs against the queue in their due cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        outSeen++;
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected output", int'(outData), -1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(int'(outData) == it.data, it.tag, int'(outData), it.data);
          check(cycleCount == it.due, {it.tag, " R7 timing"}, int'(cycleCount), int'(it.due));
        end
      end else if (expQ.size() != 0 && expQ[0].due <= cycleCount) begin
        expItem_t it;
        it = expQ.pop_front();
        check(1'b0, {it.tag, " R7 missing"}, 0, it.data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: outputs idle in reset
    check(outValid == 1'b0, "R10 outValid in reset", int'(outValid), 0);
    check(outData == '0, "R10 outData in reset", int'(outData), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10: lines before any field start are ignored
    driveLine(1'b0, LINE_LEN, 200, 3, 1, "R10");
    driveLine(1'b0, LINE_LEN, 100, 5, 1, "R10");
    driveLine(1'b0, LINE_LEN, 50, 7, 1, "R10");
    repeat (4) @(negedge clk);
    check(outSeen == 0, "R10 output before field", outSeen, 0);

    // R2 / R1: mode 00, six lines -> two output lines
    modeSel = 2'b00;
    driveLine(1'b1, LINE_LEN, 10, 17, 2, "R2");
    driveLine(1'b0, LINE_LEN, 90, 31, 0, "R2");
    driveLine(1'b0, LINE_LEN, 33, 9, 3, "R2");
    driveLine(1'b0, LINE_LEN, 250, 13, 1, "R1");
    driveLine(1'b0, LINE_LEN, 7, 41, 0, "R1");
    driveLine(1'b0, LINE_LEN, 128, 1, 2, "R1");

    // R6: rounding half up and full-scale input
    driveLine(1'b0, LINE_LEN, 2, 0, 1, "R6");
    driveLine(1'b0, LINE_LEN, 0, 0, 1, "R6");
    driveLine(1'b0, LINE_LEN, 0, 0, 1, "R6");
    driveLine(1'b0, LINE_LEN, 1, 0, 1, "R6");
    driveLine(1'b0, LINE_LEN, 0, 0, 1, "R6");
    driveLine(1'b0, LINE_LEN, 0, 0, 1, "R6");
    driveLine(1'b0, LINE_LEN, 255, 0, 1, "R6");
    driveLine(1'b0, LINE_LEN, 255, 0, 1, "R6");
    driveLine(1'b0, LINE_LEN, 255, 0, 1, "R6");

    // R9: mode change mid-field keeps the running mode
    modeSel = 2'b11;
    driveLine(1'b0, LINE_LEN, 60, 23, 1, "R9");
    driveLine(1'b0, LINE_LEN, 180, 11, 1, "R9");
    driveLine(1'b0, LINE_LEN, 5, 37, 1, "R9");

    // R5: mode 11 picked up at the field start
    driveLine(1'b1, LINE_LEN, 12, 19, 1, "R5");
    driveLine(1'b0, LINE_LEN, 240, 3, 0, "R5");
    driveLine(1'b0, LINE_LEN, 77, 29, 1, "R5");
    driveLine(1'b0, LINE_LEN, 150, 47, 1, "R5");
    driveLine(1'b0, LINE_LEN, 31, 61, 0, "R5");
    driveLine(1'b0, LINE_LEN, 200, 5, 1, "R5");

    // R8: partial group dropped at the next field start
    driveLine(1'b0, LINE_LEN, 99, 99, 1, "R8");
    driveLine(1'b0, LINE_LEN, 44, 12, 1, "R8");
    modeSel = 2'b01;
    driveLine(1'b1, LINE_LEN, 20, 27, 1, "R3");
    driveLine(1'b0, LINE_LEN, 170, 8, 1, "R3");
    driveLine(1'b0, LINE_LEN, 66, 53, 0, "R3");
    driveLine(1'b0, LINE_LEN, 3, 71, 1, "R3 R8");

    // R4: mode 10, then an over-long line (R11)
    modeSel = 2'b10;
    driveLine(1'b1, LINE_LEN, 140, 21, 1, "R4");
    driveLine(1'b0, LINE_LEN, 15, 43, 1, "R4");
    driveLine(1'b0, LINE_LEN, 222, 6, 0, "R4");
    driveLine(1'b0, LINE_LEN, 88, 14, 1, "R4");
    driveLine(1'b0, LINE_LEN, 41, 39, 1, "R4");
    driveLine(1'b0, LINE_LEN + 3, 9, 33, 1, "R11");
    driveLine(1'b0, LINE_LEN, 111, 2, 1, "R11");
    driveLine(1'b0, LINE_LEN + 5, 230, 17, 1, "R11");
    driveLine(1'b0, LINE_LEN, 60, 10, 1, "R11");
    driveLine(1'b0, LINE_LEN + 2, 190, 25, 1, "R11");

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R7 pending results", expQ.size(), 0);
    check(outSeen == pushed, "R1 output count", outSeen, pushed);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule